// File: doc/BRIEF.md
# Color LCD Controller Register Bank

This block is the software-visible register file of a simple color LCD controller. A processor reaches it through a 32-bit, word-addressed peripheral port that spans a 4 KB window, so it sees 1024 word slots. It holds four panel timing words, two frame base addresses (one for the upper panel half and one for the lower), a control word and an interrupt mask. Interrupt state is kept as raw status bits. These bits can be read directly, read through the mask, and cleared by writing ones. A small read-only identification area sits at the top of the window.

The block turns the encoded timing fields into the active pixel count per line and the active line count per frame. It also exports the display-on signal and the pixel-format controls to the fetch and timing logic. Palette entries live in a separate storage block. This bank decodes the palette window, forwards index, data and strobes to that block, and returns its read data. Every access takes one cycle: writes land at the clock edge and read data appears on the following cycle.

Top module: `lcd_reg_bank`

## Requirements
- R1: After reset every stored register is zero. As a result `dispOn`, `irqOut` and `busErr` are 0, `pixelsPerLine` is 16 and `linesPerFrame` is 1.
- R2: Word addresses 0–3 (timing), 4 (upper base), 5 (lower base), 6 (mask) and 7 (control) store writes. The mask keeps only its low IRQ_W bits. A read returns the stored value on `busRdata` in the cycle after the access.
- R3: `pixelsPerLine` equals ((timing0 & 0xFC) + 4) * 4.
- R4: `linesPerFrame` equals (timing1 & 0x3FF) + 1.
- R5: Control bits [3:1] drive `bppMode`, bit 8 drives `bgrOrder`, bit 9 drives `beByteOrder` and bit 10 drives `bePixelOrder`.
- R6: `dispOn` is 1 only when control bit 0 (enable) and control bit 11 (power) are both 1.
- R7: Word addresses 1016–1023 (byte offsets 0xFE0–0xFFC) read the identification bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one per word, in the low byte.
- R8: A 1 on any `irqSrc` bit sets that raw status bit. Word 8 reads the raw status. A write to word 10 clears each raw bit written as 1. When a source sets a bit in the same cycle that a write clears it, the set wins. Word 10 reads zero.
- R9: Word 9 reads raw status AND mask. `irqOut` is the OR of those masked bits.
- R10: Word 11 reads the upper base and word 12 reads the lower base. Writes to words 8, 9, 11 and 12 are ignored and raise no error.
- R11: Word addresses 128–255 form the palette window. There, `palSel` is 1, `palIndex` is the word address minus 128, `palWrite` follows the access direction, and a read returns `palRdata`.
- R12: Any other word address reads zero and ignores writes. `busErr` is 1 for exactly the cycle after each such access and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Word address (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after access |
| busErr | output | 1 | Unmapped-access pulse, one cycle after access |
| irqSrc | input | IRQ_W | Interrupt set events |
| irqOut | output | 1 | Combined masked interrupt |
| palSel | output | 1 | Palette window access |
| palWrite | output | 1 | Palette write strobe |
| palIndex | output | 7 | Palette entry index |
| palWdata | output | 32 | Palette write data |
| palRdata | input | 32 | Palette read data for `palIndex` |
| dispOn | output | 1 | Display enabled and powered |
| bppMode | output | 3 | Bits-per-pixel code |
| bgrOrder | output | 1 | Swap red and blue |
| beByteOrder | output | 1 | Big-endian byte order |
| bePixelOrder | output | 1 | Big-endian pixel order in a byte |
| pixelsPerLine | output | 11 | Active pixels per line |
| linesPerFrame | output | 11 | Active lines per frame |
| upperBase | output | 32 | Upper panel frame base |
| lowerBase | output | 32 | Lower panel frame base |
| timingH | output | 32 | Timing word 2 |
| timingV | output | 32 | Timing word 3 |

## Verification
The assertions assume that the requester presents one access at a time, with `busSel`, `busWrite`, `busAddr` and `busWdata` held steady around the rising edge. They also assume that the palette store answers `palRdata` combinationally for the presented index. The bench changes every input only at the falling clock edge and keeps each access to a single cycle. It models the palette store as a zero-latency array, so these assumptions always hold. Interrupt events are likewise driven for single cycles at the falling edge. The one deliberate overlap is a clear write and a set event in the same cycle, which tests the set-wins rule.

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int GEOM_W   = 11;
  localparam int PAL_IW   = 7;
  localparam int ID_COUNT = 8;
  localparam int ID_IW    = $clog2(ID_COUNT);

  localparam logic [ADDR_W-1:0] W_UPPER  = 10'd4;
  localparam logic [ADDR_W-1:0] W_LOWER  = 10'd5;
  localparam logic [ADDR_W-1:0] W_MASK   = 10'd6;
  localparam logic [ADDR_W-1:0] W_CTRL   = 10'd7;
  localparam logic [ADDR_W-1:0] W_RAW    = 10'd8;
  localparam logic [ADDR_W-1:0] W_MSKD   = 10'd9;
  localparam logic [ADDR_W-1:0] W_CLEAR  = 10'd10;
  localparam logic [ADDR_W-1:0] W_UCUR   = 10'd11;
  localparam logic [ADDR_W-1:0] W_LCUR   = 10'd12;
  localparam logic [ADDR_W-1:0] W_PALLO  = 10'd128;
  localparam logic [ADDR_W-1:0] W_PALHI  = 10'd255;
  localparam logic [ADDR_W-1:0] W_IDLO   = 10'd1016;

  localparam int B_EN   = 0;
  localparam int B_BGR  = 8;
  localparam int B_BEB  = 9;
  localparam int B_BEP  = 10;
  localparam int B_PWR  = 11;

  typedef enum logic [3:0] {
    RD_NONE, RD_TIMING, RD_UPPER, RD_LOWER, RD_MASK,
    RD_CTRL, RD_RAW, RD_MASKED, RD_ID, RD_PAL
  } rdSelT;

  typedef struct packed {
    logic [3:0]       wrTiming;
    logic             wrUpper;
    logic             wrLower;
    logic             wrMask;
    logic             wrCtrl;
    logic             wrClear;
    logic             palAcc;
    logic             palWr;
    logic             unmapped;
    rdSelT            rdSel;
    logic [1:0]       timIdx;
    logic [ID_IW-1:0] idIdx;
  } strobeT;

  function automatic logic [7:0] idByte(input logic [ID_IW-1:0] idx);
    case (idx)
      3'd0: idByte = 8'h10;
      3'd1: idByte = 8'h11;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/lcd_reg_ctrl.sv
module lcd_reg_ctrl
  import lcd_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobeT            stb,
  output logic              busErr
);
  logic inPal;
  logic inId;

  assign inPal = (busAddr >= W_PALLO) && (busAddr <= W_PALHI);
  assign inId  = (busAddr >= W_IDLO);

  always_comb begin
    stb = '0;
    if (busSel) begin
      if (busAddr < W_UPPER) begin
        stb.timIdx = busAddr[1:0];
        if (busWrite) stb.wrTiming[busAddr[1:0]] = 1'b1;
        else          stb.rdSel = RD_TIMING;
      end else if (busAddr == W_UPPER) begin
        if (busWrite) stb.wrUpper = 1'b1; else stb.rdSel = RD_UPPER;
      end else if (busAddr == W_LOWER) begin
        if (busWrite) stb.wrLower = 1'b1; else stb.rdSel = RD_LOWER;
      end else if (busAddr == W_MASK) begin
        if (busWrite) stb.wrMask = 1'b1; else stb.rdSel = RD_MASK;
      end else if (busAddr == W_CTRL) begin
        if (busWrite) stb.wrCtrl = 1'b1; else stb.rdSel = RD_CTRL;
      end else if (busAddr == W_RAW) begin
        if (!busWrite) stb.rdSel = RD_RAW;
      end else if (busAddr == W_MSKD) begin
        if (!busWrite) stb.rdSel = RD_MASKED;
      end else if (busAddr == W_CLEAR) begin
        if (busWrite) stb.wrClear = 1'b1;
      end else if (busAddr == W_UCUR) begin
        if (!busWrite) stb.rdSel = RD_UPPER;
      end else if (busAddr == W_LCUR) begin
        if (!busWrite) stb.rdSel = RD_LOWER;
      end else if (inPal) begin
        stb.palAcc = 1'b1;
        stb.palWr  = busWrite;
        if (!busWrite) stb.rdSel = RD_PAL;
      end else if (inId) begin
        stb.idIdx = busAddr[ID_IW-1:0];
        if (!busWrite) stb.rdSel = RD_ID;
      end else begin
        stb.unmapped = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= stb.unmapped;
  end
endmodule

// File: rtl/lcd_reg_data.sv
module lcd_reg_data
  import lcd_reg_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [IRQ_W-1:0]  irqSrc,
  input  logic [DATA_W-1:0] palRdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic [DATA_W-1:0] ctrlReg,
  output logic [DATA_W-1:0] timing0,
  output logic [DATA_W-1:0] timing1,
  output logic [DATA_W-1:0] timing2,
  output logic [DATA_W-1:0] timing3,
  output logic [DATA_W-1:0] upperReg,
  output logic [DATA_W-1:0] lowerReg
);
  logic [DATA_W-1:0] timingReg [4];
  logic [IRQ_W-1:0]  maskReg;
  logic [IRQ_W-1:0]  rawStat;
  logic [IRQ_W-1:0]  clrBits;
  logic [IRQ_W-1:0]  maskedStat;
  logic [DATA_W-1:0] readMux;

  for (genvar g = 0; g < 4; g++) begin : g_timing
    always_ff @(posedge clk) begin
      if (!rstN)                timingReg[g] <= '0;
      else if (stb.wrTiming[g]) timingReg[g] <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperReg <= '0;
      lowerReg <= '0;
      maskReg  <= '0;
      ctrlReg  <= '0;
    end else begin
      if (stb.wrUpper) upperReg <= busWdata;
      if (stb.wrLower) lowerReg <= busWdata;
      if (stb.wrMask)  maskReg  <= busWdata[IRQ_W-1:0];
      if (stb.wrCtrl)  ctrlReg  <= busWdata;
    end
  end

  assign clrBits = stb.wrClear ? busWdata[IRQ_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) rawStat <= '0;
    else       rawStat <= (rawStat & ~clrBits) | irqSrc;
  end

  assign maskedStat = rawStat & maskReg;
  assign irqOut     = |maskedStat;

  always_comb begin
    readMux = '0;
    case (stb.rdSel)
      RD_TIMING: readMux = timingReg[stb.timIdx];
      RD_UPPER:  readMux = upperReg;
      RD_LOWER:  readMux = lowerReg;
      RD_MASK:   readMux[IRQ_W-1:0] = maskReg;
      RD_CTRL:   readMux = ctrlReg;
      RD_RAW:    readMux[IRQ_W-1:0] = rawStat;
      RD_MASKED: readMux[IRQ_W-1:0] = maskedStat;
      RD_ID:     readMux[7:0] = idByte(stb.idIdx);
      RD_PAL:    readMux = palRdata;
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= readMux;
  end

  assign timing0 = timingReg[0];
  assign timing1 = timingReg[1];
  assign timing2 = timingReg[2];
  assign timing3 = timingReg[3];
endmodule

// File: rtl/lcd_reg_bank.sv
module lcd_reg_bank
  import lcd_reg_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  input  logic [IRQ_W-1:0]  irqSrc,
  output logic              irqOut,
  output logic              palSel,
  output logic              palWrite,
  output logic [PAL_IW-1:0] palIndex,
  output logic [DATA_W-1:0] palWdata,
  input  logic [DATA_W-1:0] palRdata,
  output logic              dispOn,
  output logic [2:0]        bppMode,
  output logic              bgrOrder,
  output logic              beByteOrder,
  output logic              bePixelOrder,
  output logic [GEOM_W-1:0] pixelsPerLine,
  output logic [GEOM_W-1:0] linesPerFrame,
  output logic [DATA_W-1:0] upperBase,
  output logic [DATA_W-1:0] lowerBase,
  output logic [DATA_W-1:0] timingH,
  output logic [DATA_W-1:0] timingV
);
  strobeT            stb;
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] timing0;
  logic [DATA_W-1:0] timing1;

  lcd_reg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .stb(stb), .busErr(busErr)
  );

  lcd_reg_data #(.IRQ_W(IRQ_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .irqSrc(irqSrc), .palRdata(palRdata), .busRdata(busRdata),
    .irqOut(irqOut), .ctrlReg(ctrlReg), .timing0(timing0),
    .timing1(timing1), .timing2(timingH), .timing3(timingV),
    .upperReg(upperBase), .lowerReg(lowerBase)
  );

  assign palSel   = stb.palAcc;
  assign palWrite = stb.palWr;
  assign palIndex = busAddr[PAL_IW-1:0];
  assign palWdata = busWdata;

  // ((t0 & 0xFC) + 4) * 4 == (t0[7:2] + 1) * 16
  assign pixelsPerLine = (GEOM_W'(timing0[7:2]) + GEOM_W'(1)) << 4;
  assign linesPerFrame = GEOM_W'(timing1[9:0]) + GEOM_W'(1);

  assign dispOn       = ctrlReg[B_EN] & ctrlReg[B_PWR];
  assign bppMode      = ctrlReg[3:1];
  assign bgrOrder     = ctrlReg[B_BGR];
  assign beByteOrder  = ctrlReg[B_BEB];
  assign bePixelOrder = ctrlReg[B_BEP];
endmodule

// File: rtl/lcd_reg_bank_chk.sv
module lcd_reg_bank_chk
  import lcd_reg_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busErr,
  input logic [IRQ_W-1:0]  irqSrc,
  input logic              irqOut,
  input logic              dispOn,
  input logic [GEOM_W-1:0] pixelsPerLine,
  input logic [GEOM_W-1:0] linesPerFrame
);
  assert_err_after_access_R12: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busSel));

  assert_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == W_CLEAR && (&busWdata[IRQ_W-1:0]) && irqSrc == '0)
    |=> !irqOut);

  assert_disp_needs_ctrl_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWrite && busAddr == W_CTRL) |=> $stable(dispOn));

  assert_width_multiple_R3: assert property (@(posedge clk) disable iff (!rstN)
    pixelsPerLine[3:0] == 4'd0 && pixelsPerLine != '0);

  assert_height_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    linesPerFrame != '0);
endmodule

bind lcd_reg_bank lcd_reg_bank_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busErr(busErr),
  .irqSrc(irqSrc), .irqOut(irqOut), .dispOn(dispOn),
  .pixelsPerLine(pixelsPerLine), .linesPerFrame(linesPerFrame)
);

// File: tb/lcd_reg_bank_bench.sv
`timescale 1ns/1ps
module lcd_reg_bank_bench;
  localparam int IRQ_W = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic [3:0]  irqSrc = '0;
  logic        irqOut;
  logic        palSel, palWrite;
  logic [6:0]  palIndex;
  logic [31:0] palWdata, palRdata;
  logic        dispOn;
  logic [2:0]  bppMode;
  logic        bgrOrder, beByteOrder, bePixelOrder;
  logic [10:0] pixelsPerLine, linesPerFrame;
  logic [31:0] upperBase, lowerBase, timingH, timingV;

  int checks = 0;
  int failures = 0;
  logic [31:0] rdVal;
  logic        rdErr;
  logic [31:0] palMem [128];

  always #4 clk = ~clk;

  lcd_reg_bank #(.IRQ_W(IRQ_W)) u_lcd_reg_bank (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .irqSrc(irqSrc), .irqOut(irqOut), .palSel(palSel),
    .palWrite(palWrite), .palIndex(palIndex), .palWdata(palWdata),
    .palRdata(palRdata), .dispOn(dispOn), .bppMode(bppMode),
    .bgrOrder(bgrOrder), .beByteOrder(beByteOrder),
    .bePixelOrder(bePixelOrder), .pixelsPerLine(pixelsPerLine),
    .linesPerFrame(linesPerFrame), .upperBase(upperBase),
    .lowerBase(lowerBase), .timingH(timingH), .timingV(timingV)
  );

  assign palRdata = palMem[palIndex];
  always @(posedge clk) if (palSel && palWrite) palMem[palIndex] <= palWdata;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    rdErr = busErr;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [9:0] a);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    rdVal = busRdata; rdErr = busErr;
  endtask

  task automatic pulseIrq(input logic [3:0] s);
    @(negedge clk); irqSrc = s;
    @(negedge clk); irqSrc = '0;
  endtask

  task automatic testReset();
    check(dispOn == 0 && irqOut == 0 && busErr == 0, "R1 outputs",
          {29'd0, dispOn, irqOut, busErr}, 0);
    check(pixelsPerLine == 16, "R1 width", 32'(pixelsPerLine), 16);
    check(linesPerFrame == 1, "R1 height", 32'(linesPerFrame), 1);
    for (int w = 0; w < 13; w++) begin
      busRd(10'(w));
      check(rdVal == 0 && !rdErr, "R1 register zero", rdVal, 0);
    end
  endtask

  task automatic testStorage();
    busWr(10'd0, 32'hA5A5_0013);
    busWr(10'd1, 32'h1234_5678);
    busWr(10'd2, 32'hDEAD_BEEF);
    busWr(10'd3, 32'h0BAD_F00D);
    busWr(10'd4, 32'h8000_1000);
    busWr(10'd5, 32'h8004_0000);
    busWr(10'd6, 32'hFFFF_FFFF);
    busRd(10'd0); check(rdVal == 32'hA5A5_0013, "R2 timing0", rdVal, 32'hA5A5_0013);
    busRd(10'd2); check(rdVal == 32'hDEAD_BEEF, "R2 timing2", rdVal, 32'hDEAD_BEEF);
    check(timingH == 32'hDEAD_BEEF && timingV == 32'h0BAD_F00D, "R2 timing ports",
          timingV, 32'h0BAD_F00D);
    busRd(10'd3); check(rdVal == 32'h0BAD_F00D, "R2 timing3", rdVal, 32'h0BAD_F00D);
    busRd(10'd6); check(rdVal == 32'h0000_000F, "R2 mask width", rdVal, 32'hF);
    check(upperBase == 32'h8000_1000 && lowerBase == 32'h8004_0000, "R2 base ports",
          upperBase, 32'h8000_1000);
    busWr(10'd6, 32'h0);
  endtask

  task automatic testGeometry();
    busWr(10'd0, 32'h0000_0013);
    check(pixelsPerLine == 80, "R3 width 0x13", 32'(pixelsPerLine), 80);
    busWr(10'd0, 32'hFFFF_FFFF);
    check(pixelsPerLine == 1024, "R3 width max", 32'(pixelsPerLine), 1024);
    busWr(10'd0, 32'h0000_0003);
    check(pixelsPerLine == 16, "R3 width low bits ignored", 32'(pixelsPerLine), 16);
    busWr(10'd1, 32'hFFFF_FC07);
    check(linesPerFrame == 8, "R4 height 7", 32'(linesPerFrame), 8);
    busWr(10'd1, 32'h0000_03FF);
    check(linesPerFrame == 1024, "R4 height max", 32'(linesPerFrame), 1024);
  endtask

  task automatic testControl();
    busWr(10'd7, 32'h0000_0F0B);
    check(bppMode == 3'd5, "R5 bpp", 32'(bppMode), 5);
    check(bgrOrder && beByteOrder && bePixelOrder, "R5 order bits",
          {29'd0, bgrOrder, beByteOrder, bePixelOrder}, 7);
    check(dispOn == 1, "R6 enable+power", 32'(dispOn), 1);
    busWr(10'd7, 32'h0000_0001);
    check(dispOn == 0, "R6 enable only", 32'(dispOn), 0);
    check(!bgrOrder && !beByteOrder && !bePixelOrder && bppMode == 0, "R5 cleared",
          {28'd0, bppMode, bgrOrder}, 0);
    busWr(10'd7, 32'h0000_0800);
    check(dispOn == 0, "R6 power only", 32'(dispOn), 0);
    busWr(10'd7, 32'h0000_0204);
    check(beByteOrder && !bgrOrder && !bePixelOrder && bppMode == 3'd2,
          "R5 byte order alone", {28'd0, bppMode, beByteOrder}, 32'h5);
    busRd(10'd7); check(rdVal == 32'h0000_0204, "R2 control readback", rdVal, 32'h204);
  endtask

  task automatic testId();
    logic [7:0] idExp [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      busRd(10'(1016 + i));
      check(rdVal == {24'd0, idExp[i]} && !rdErr, "R7 id byte", rdVal, {24'd0, idExp[i]});
    end
  endtask

  task automatic testIrq();
    busWr(10'd6, 32'h5);
    pulseIrq(4'hA);
    busRd(10'd8); check(rdVal == 32'hA, "R8 raw set", rdVal, 32'hA);
    busRd(10'd9); check(rdVal == 32'h0, "R9 masked none", rdVal, 0);
    check(irqOut == 0, "R9 irq low", 32'(irqOut), 0);
    pulseIrq(4'h1);
    busRd(10'd9); check(rdVal == 32'h1, "R9 masked", rdVal, 1);
    check(irqOut == 1, "R9 irq high", 32'(irqOut), 1);
    busWr(10'd10, 32'h1);
    check(irqOut == 0, "R8 clear drops irq", 32'(irqOut), 0);
    busRd(10'd8); check(rdVal == 32'hA, "R8 partial clear", rdVal, 32'hA);
    // set and clear of bit 1 in the same cycle: set wins
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 10'd10; busWdata = 32'h2; irqSrc = 4'h2;
    @(negedge clk);
    busSel = 0; busWrite = 0; irqSrc = 0;
    busRd(10'd8); check(rdVal == 32'hA, "R8 set wins", rdVal, 32'hA);
    busRd(10'd10); check(rdVal == 0 && !rdErr, "R8 clear word reads zero", rdVal, 0);
    busWr(10'd8, 32'h0);
    busRd(10'd8); check(rdVal == 32'hA, "R10 raw write ignored", rdVal, 32'hA);
    busWr(10'd10, 32'hFFFF_FFFF);
    busRd(10'd8); check(rdVal == 0, "R8 clear all", rdVal, 0);
    busWr(10'd6, 32'h0);
  endtask

  task automatic testCurrent();
    busWr(10'd4, 32'h1234_5670);
    busWr(10'd5, 32'h0ABC_0000);
    busRd(10'd11); check(rdVal == 32'h1234_5670, "R10 upper current", rdVal, 32'h1234_5670);
    busRd(10'd12); check(rdVal == 32'h0ABC_0000, "R10 lower current", rdVal, 32'h0ABC_0000);
    busWr(10'd11, 32'h0);
    check(!rdErr, "R10 no error on ro write", 32'(rdErr), 0);
    check(upperBase == 32'h1234_5670, "R10 ro write ignored", upperBase, 32'h1234_5670);
  endtask

  task automatic testPalette();
    busWr(10'd133, 32'hCAFE_0005);
    busWr(10'd255, 32'h7777_0127);
    busWr(10'd128, 32'h1111_0000);
    check(palMem[5] == 32'hCAFE_0005, "R11 palette index 5", palMem[5], 32'hCAFE_0005);
    check(palMem[127] == 32'h7777_0127, "R11 palette top", palMem[127], 32'h7777_0127);
    busRd(10'd133); check(rdVal == 32'hCAFE_0005, "R11 palette read", rdVal, 32'hCAFE_0005);
    busRd(10'd128); check(rdVal == 32'h1111_0000, "R11 palette base", rdVal, 32'h1111_0000);
  endtask

  task automatic testUnmapped();
    logic [31:0] t2;
    busRd(10'd2); t2 = rdVal;
    busWr(10'd13, 32'hFFFF_FFFF);
    check(rdErr == 1, "R12 write error", 32'(rdErr), 1);
    @(negedge clk);
    check(busErr == 0, "R12 error one cycle", 32'(busErr), 0);
    busRd(10'd13);
    check(rdVal == 0 && rdErr, "R12 read zero+err", rdVal, 0);
    busRd(10'd300);
    check(rdVal == 0 && rdErr, "R12 gap read", rdVal, 0);
    busRd(10'd2);
    check(rdVal == t2 && !rdErr, "R12 write ignored", rdVal, t2);
    busWr(10'd127, 32'h0);
    check(rdErr == 1, "R12 below palette", 32'(rdErr), 1);
    busRd(10'd1015);
    check(rdErr == 1 && rdVal == 0, "R12 below id", rdVal, 0);
  endtask

  initial begin : watchdog
    #(8 * 20000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStorage();
    testGeometry();
    testControl();
    testId();
    testIrq();
    testCurrent();
    testPalette();
    testUnmapped();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule